// File: doc/BRIEF.md
# Receive Ring Start-of-Packet Scanner

This block walks the circular receive descriptor ring of a DMA receive engine once a packet has been fully written back. It finds the entry where the next packet must start. When look-ahead mode is on, only entries flagged as start-of-packet may begin a packet. The walk begins at the entry after the packet's last descriptor and passes over other entries whatever their ownership. Entries the controller owns but that are not starts are handed back to the host by clearing their ownership flag. An entry that is a start but still belongs to the host stops the walk, and that entry is then re-read at a programmed interval. An entry that is a start and is owned by the controller ends the walk: its index and buffer information are latched and `next_ready` is raised until the next packet completes.

When look-ahead mode is off, the start-of-packet flag is not consulted. The entry after the last one is taken directly, or polled if the host still owns it, and no ownership flag is cleared. If a whole lap of the ring holds no start entry, the scanner returns to the entry where the lap began and polls it until it becomes a controller-owned start entry.

Descriptors are reached over a request/acknowledge port. The scanner raises `mem_req` with a stable address and direction and holds them until `mem_ack` is seen on a clock edge. The responder may therefore stretch any access by any number of cycles; that is the only form of back-pressure. Read data are sampled in the acknowledge cycle. A write (`mem_we`=1) always means "clear the ownership flag of this entry". `pkt_done` is a one-cycle pulse and is only accepted while the scanner is idle or holding a result. `ring_base`, `ring_len`, `lookahead_en`, `poll_interval` and `last_idx` must stay stable while a scan is in progress.

Top module: `rx_sop_scanner`

## Requirements
- R1: After a `pkt_done` pulse carrying `last_idx`, the first descriptor read is at entry `last_idx+1`, with entry `ring_len-1` wrapping to entry 0.
- R2: In look-ahead mode the result index is the first entry at or after the starting entry, in ring order, whose start-of-packet flag is set, regardless of the ownership of the entries passed.
- R3: In look-ahead mode, a read entry that is controller-owned (own=1) with start-of-packet clear (sop=0) receives one write (`mem_we`=1) that clears its ownership, and the walk then continues. A write happens only to such entries, and only directly after the read of that entry.
- R4: A read entry that is host-owned (own=0) with sop=0 is never written.
- R5: A start entry with own=0 is re-read until it becomes controller-owned. Between the acknowledge of one read of it and the next request, `mem_req` is low for exactly `poll_interval+1` cycles.
- R6: A start entry with own=1 ends the walk. `next_idx` and `next_buf` hold that entry's index and buffer field, `next_ready` is 1, and no memory request is made until the next `pkt_done`.
- R7: With `lookahead_en`=0 the scanner reads only entry `last_idx+1`, takes it whatever its sop flag is (polling it while own=0), and never writes.
- R8: If a lap of `ring_len` entries finds no start entry, the scanner reads only the lap's first entry from then on, at the poll interval, until that entry holds sop=1 and own=1. It then takes that entry.
- R9: While `mem_req` is high and `mem_ack` is low, the request, its address and its direction stay unchanged in the next cycle.
- R10: The descriptor address is `ring_base + 16*index`, and the index is always below `ring_len`.
- R11: After reset, `next_ready` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of ring entry 0 |
| ring_len | input | LEN_W | Number of ring entries (1 to 2^IDX_W) |
| lookahead_en | input | 1 | 1 = search for start-of-packet entries |
| poll_interval | input | POLL_W | Idle cycles minus one between poll reads |
| pkt_done | input | 1 | Pulse: last descriptor of a packet written back |
| last_idx | input | IDX_W | Index of that packet's last descriptor |
| mem_req | output | 1 | Descriptor access request |
| mem_we | output | 1 | 1 = clear ownership of the entry, 0 = read it |
| mem_addr | output | ADDR_W | Descriptor byte address |
| mem_ack | input | 1 | Access completes on this edge |
| mem_rd_own | input | 1 | Read data: 1 = controller owns the entry |
| mem_rd_sop | input | 1 | Read data: start-of-packet flag |
| mem_rd_buf | input | BUF_W | Read data: buffer information |
| next_idx | output | IDX_W | Index of the next packet's start entry |
| next_buf | output | BUF_W | Buffer information of that entry |
| next_ready | output | 1 | Result valid, scanner waiting for next packet |

## Verification
The hardest situation to reach from the ports is the lap fallback. It needs a whole ring in which no entry is a start entry, and then a change to one entry's flags while the scanner is polling it. The bench builds such a ring directly, with one controller-owned entry inside it so that reclaiming is also seen during the lap. It waits until the responder has served the lap's first entry several times, confirms that every other entry was read exactly once, and only then turns that entry into a controller-owned start. Polling of host-owned starts is reached by the same method: the bench grants ownership of an entry only after it has seen repeated reads of it, so the idle gap between reads can be measured.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CLEAR,
    ST_POLL,
    ST_HOLD
  } scan_st_t;

  typedef enum logic [1:0] {
    EC_PASS,      // not a start, host owned: leave it
    EC_RECLAIM,   // not a start, controller owned: clear ownership
    EC_WAIT,      // start, host owned: poll it
    EC_TAKE       // start, controller owned: done
  } entry_class_t;

  function automatic entry_class_t classify(input logic own,
                                            input logic sop,
                                            input logic la_mode);
    logic is_start;
    is_start = sop | ~la_mode;
    if (is_start) return own ? EC_TAKE : EC_WAIT;
    else          return own ? EC_RECLAIM : EC_PASS;
  endfunction

endpackage

// File: rtl/rxs_ring_wrap.sv
module rxs_ring_wrap #(
  parameter int IDX_W = 7,
  parameter int LEN_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LEN_W-1:0] ring_len,
  output logic [IDX_W-1:0] idx_next
);
  logic [LEN_W-1:0] inc;

  always_comb begin
    inc = LEN_W'(idx) + LEN_W'(1);
    idx_next = (inc >= ring_len) ? '0 : inc[IDX_W-1:0];
  end
endmodule

// File: rtl/rxs_poll_timer.sv
module rxs_poll_timer #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [POLL_W-1:0] interval,
  output logic              busy,
  output logic              expired
);
  logic [POLL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= interval;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign expired = busy && (cnt == '0);

  // R5: the wait shrinks by one every cycle until it runs out
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !load) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rxs_scan_ctrl.sv
module rxs_scan_ctrl
  import rxs_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int LEN_W = IDX_W + 1,
  parameter int BUF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookahead_en,
  input  logic             pkt_done,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [LEN_W-1:0] ring_len,
  input  logic [IDX_W-1:0] step_idx,
  input  logic             mem_ack,
  input  logic             rd_own,
  input  logic             rd_sop,
  input  logic [BUF_W-1:0] rd_buf,
  input  logic             timer_expired,
  output logic [IDX_W-1:0] cur_idx,
  output logic             timer_load,
  output logic             mem_req,
  output logic             mem_we,
  output logic [IDX_W-1:0] next_idx,
  output logic [BUF_W-1:0] next_buf,
  output logic             next_ready
);
  scan_st_t         st;
  entry_class_t     cls;
  logic             la_mode;
  logic             fallback;
  logic [IDX_W-1:0] origin;
  logic [LEN_W-1:0] lap_cnt;
  logic             lap_end;
  logic             advance;
  logic             rd_done;

  always_comb begin
    cls     = classify(rd_own, rd_sop, la_mode);
    rd_done = (st == ST_READ) && mem_ack;
    lap_end = (LEN_W'(lap_cnt + 1'b1) >= ring_len);
    advance = (rd_done && !fallback && cls == EC_PASS) ||
              ((st == ST_CLEAR) && mem_ack);
    timer_load = (rd_done && (fallback ? (cls != EC_TAKE) : (cls == EC_WAIT))) ||
                 (advance && lap_end);
    mem_req = (st == ST_READ) || (st == ST_CLEAR);
    mem_we  = (st == ST_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      la_mode    <= 1'b0;
      fallback   <= 1'b0;
      origin     <= '0;
      cur_idx    <= '0;
      lap_cnt    <= '0;
      next_idx   <= '0;
      next_buf   <= '0;
      next_ready <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_HOLD: begin
          if (pkt_done) begin
            cur_idx    <= start_idx;
            origin     <= start_idx;
            lap_cnt    <= '0;
            la_mode    <= lookahead_en;
            fallback   <= 1'b0;
            next_ready <= 1'b0;
            st         <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            if (cls == EC_TAKE) begin
              next_idx   <= cur_idx;
              next_buf   <= rd_buf;
              next_ready <= 1'b1;
              st         <= ST_HOLD;
            end else if (fallback || cls == EC_WAIT) begin
              st <= ST_POLL;
            end else if (cls == EC_RECLAIM) begin
              st <= ST_CLEAR;
            end
          end
        end
        ST_CLEAR: ;
        ST_POLL: begin
          if (timer_expired) st <= ST_READ;
        end
        default: st <= ST_IDLE;
      endcase

      if (advance) begin
        if (lap_end) begin
          cur_idx  <= origin;
          fallback <= 1'b1;
          st       <= ST_POLL;
        end else begin
          cur_idx <= step_idx;
          lap_cnt <= lap_cnt + 1'b1;
          st      <= ST_READ;
        end
      end
    end
  end

  // R9: an access is held until acknowledged
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(cur_idx)));
  // R6: a latched result keeps the memory port quiet
  assert_quiet_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    next_ready |-> !mem_req);
  // R3: a clear follows the read of the same entry
  assert_clear_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> ($past(mem_ack) && $stable(cur_idx)));
  // R7: without look-ahead no ownership is ever cleared
  assert_no_clear_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> la_mode);
endmodule

// File: rtl/rx_sop_scanner.sv
module rx_sop_scanner #(
  parameter int IDX_W      = 7,
  parameter int ADDR_W     = 32,
  parameter int BUF_W      = 32,
  parameter int POLL_W     = 16,
  parameter int DESC_BYTES = 16,
  parameter int LEN_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LEN_W-1:0]  ring_len,
  input  logic              lookahead_en,
  input  logic [POLL_W-1:0] poll_interval,
  input  logic              pkt_done,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_rd_own,
  input  logic              mem_rd_sop,
  input  logic [BUF_W-1:0]  mem_rd_buf,
  output logic [IDX_W-1:0]  next_idx,
  output logic [BUF_W-1:0]  next_buf,
  output logic              next_ready
);
  localparam int DESC_SHIFT = $clog2(DESC_BYTES);

  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] step_idx;
  logic [IDX_W-1:0] cur_idx;
  logic             timer_load;
  logic             timer_busy;
  logic             timer_expired;

  rxs_ring_wrap #(.IDX_W(IDX_W), .LEN_W(LEN_W)) i_start_wrap (
    .idx(last_idx), .ring_len(ring_len), .idx_next(start_idx)
  );

  rxs_ring_wrap #(.IDX_W(IDX_W), .LEN_W(LEN_W)) i_step_wrap (
    .idx(cur_idx), .ring_len(ring_len), .idx_next(step_idx)
  );

  rxs_poll_timer #(.POLL_W(POLL_W)) i_poll_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .interval(poll_interval),
    .busy(timer_busy), .expired(timer_expired)
  );

  rxs_scan_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W), .BUF_W(BUF_W)) i_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .lookahead_en(lookahead_en), .pkt_done(pkt_done),
    .start_idx(start_idx), .ring_len(ring_len), .step_idx(step_idx),
    .mem_ack(mem_ack), .rd_own(mem_rd_own), .rd_sop(mem_rd_sop), .rd_buf(mem_rd_buf),
    .timer_expired(timer_expired), .cur_idx(cur_idx), .timer_load(timer_load),
    .mem_req(mem_req), .mem_we(mem_we), .next_idx(next_idx), .next_buf(next_buf),
    .next_ready(next_ready)
  );

  assign mem_addr = ring_base + (ADDR_W'(cur_idx) << DESC_SHIFT);

  // R5: no access while the poll wait runs
  assert_poll_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timer_busy |-> !mem_req);
  // R10: accesses stay inside the ring
  assert_idx_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (LEN_W'(cur_idx) < ring_len));
endmodule

// File: tb/test_rx_sop_scanner.sv
module test_rx_sop_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 7;
  localparam int LEN_W = IDX_W + 1;
  localparam int ADDR_W = 32;
  localparam int BUF_W = 32;
  localparam int POLL_W = 16;
  localparam int NENT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] ring_base = '0;
  logic [LEN_W-1:0] ring_len = LEN_W'(4);
  logic lookahead_en = 1'b1;
  logic [POLL_W-1:0] poll_interval = '0;
  logic pkt_done = 1'b0;
  logic [IDX_W-1:0] last_idx = '0;
  logic mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic mem_rd_own = 1'b0, mem_rd_sop = 1'b0;
  logic [BUF_W-1:0] mem_rd_buf = '0;
  logic [IDX_W-1:0] next_idx;
  logic [BUF_W-1:0] next_buf;
  logic next_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sop_scanner #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .BUF_W(BUF_W), .POLL_W(POLL_W))
  i_rx_sop_scanner (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_len(ring_len),
    .lookahead_en(lookahead_en), .poll_interval(poll_interval), .pkt_done(pkt_done),
    .last_idx(last_idx), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rd_own(mem_rd_own), .mem_rd_sop(mem_rd_sop),
    .mem_rd_buf(mem_rd_buf), .next_idx(next_idx), .next_buf(next_buf),
    .next_ready(next_ready)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  bit m_own [NENT];
  bit m_sop [NENT];
  logic [BUF_W-1:0] m_buf [NENT];
  int reads [NENT];
  int writes = 0;
  int gap = 0, dly = 0;
  bit last_was_rd = 0;
  int last_rd = -1;
  bit first_pending = 0;
  int exp_first = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap1(input int i, input int len);
    return (i + 1 >= len) ? 0 : i + 1;
  endfunction

  // descriptor memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      if (!rst_n) begin
        gap = 0;
      end else if (!mem_req) begin
        gap++;
      end else if (dly > 0) begin
        dly--;
      end else begin
        int off, idx;
        off = int'(mem_addr - ring_base);
        idx = off >> 4;
        chk((off % 16 == 0) && idx < int'(ring_len), "R10", "address inside ring",
            off, idx * 16);
        if (idx >= NENT) idx = 0;
        if (mem_we) begin
          chk(lookahead_en && m_own[idx] && !m_sop[idx], "R3",
              "clear only on owned non-start", idx, idx);
          m_own[idx] = 1'b0;
          writes++;
          last_was_rd = 0;
        end else begin
          if (first_pending) begin
            chk(idx == exp_first, "R1", "first read index", idx, exp_first);
            first_pending = 0;
          end
          if (last_was_rd && last_rd == idx)
            chk(gap == int'(poll_interval) + 1, "R5", "poll gap cycles",
                gap, int'(poll_interval) + 1);
          reads[idx]++;
          mem_rd_own = m_own[idx];
          mem_rd_sop = m_sop[idx];
          mem_rd_buf = m_buf[idx];
          last_was_rd = 1;
          last_rd = idx;
        end
        mem_ack = 1'b1;
        gap = 0;
        dly = $urandom % 3;
      end
    end
  end

  task automatic pulse_done(input int last);
    @(negedge clk);
    for (int i = 0; i < NENT; i++) reads[i] = 0;
    writes = 0;
    last_was_rd = 0;
    exp_first = wrap1(last, int'(ring_len));
    first_pending = 1;
    last_idx = IDX_W'(last);
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic wait_reads(input int idx, input int n, input string req);
    int t = 0;
    while (reads[idx] < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(reads[idx] >= n, req, "repeated reads of polled entry", reads[idx], n);
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    while (!next_ready && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(next_ready, req, "next_ready raised", next_ready, 1);
  endtask

  // one scan against the current ring; returns by checking results
  task automatic run_scan(input int last);
    bit exp_own [NENT];
    int len, s, i, found, pidx;
    len = int'(ring_len);
    for (int k = 0; k < NENT; k++) exp_own[k] = m_own[k];
    s = wrap1(last, len);
    found = -1; pidx = -1;
    if (!lookahead_en) begin
      if (m_own[s]) found = s; else pidx = s;
    end else begin
      i = s;
      for (int k = 0; k < len; k++) begin
        if (m_sop[i]) begin
          if (m_own[i]) found = i; else pidx = i;
          break;
        end
        if (m_own[i]) exp_own[i] = 0;
        i = wrap1(i, len);
      end
      if (found < 0 && pidx < 0) pidx = s;
    end
    pulse_done(last);
    if (pidx >= 0) begin
      wait_reads(pidx, 3, "R5");
      m_own[pidx] = 1'b1;
      m_sop[pidx] = 1'b1;
      exp_own[pidx] = 1;
      found = pidx;
    end
    wait_ready("R6");
    @(negedge clk);
    chk(int'(next_idx) == found, lookahead_en ? "R2" : "R7", "next_idx",
        next_idx, found);
    chk(next_buf == m_buf[found], "R6", "next_buf", next_buf, m_buf[found]);
    begin
      int bad = -1;
      for (int k = 0; k < len; k++) if (m_own[k] != exp_own[k]) bad = k;
      chk(bad < 0, "R4", "ownership image after scan", bad, -1);
    end
    if (!lookahead_en) chk(writes == 0, "R7", "no writes when direct", writes, 0);
    repeat (4) @(negedge clk);
    chk(next_ready && !mem_req, "R6", "held and quiet", mem_req, 0);
  endtask

  task automatic fill_random(input int len);
    for (int k = 0; k < NENT; k++) begin
      m_sop[k] = ($urandom % 4) == 0;
      m_own[k] = $urandom % 2;
      m_buf[k] = $urandom;
    end
    m_sop[$urandom % len] = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int k = 0; k < NENT; k++) begin
      m_own[k] = 0; m_sop[k] = 0; m_buf[k] = '0; reads[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!next_ready && !mem_req, "R11", "reset outputs", {next_ready, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: wrap from last entry, owned start at entry 0
    ring_len = LEN_W'(6); ring_base = 32'h0000_1000; lookahead_en = 1; poll_interval = 2;
    for (int k = 0; k < NENT; k++) begin m_own[k] = 0; m_sop[k] = 0; m_buf[k] = 32'(k + 100); end
    m_sop[0] = 1; m_own[0] = 1;
    run_scan(5);

    // directed: owned and host non-starts skipped, host start then polled
    for (int k = 0; k < 6; k++) begin m_own[k] = (k % 2); m_sop[k] = 0; end
    m_sop[4] = 1; m_own[4] = 0;
    run_scan(0);

    // directed: direct mode takes a non-start entry, owned or not
    lookahead_en = 0;
    for (int k = 0; k < 6; k++) begin m_own[k] = 1; m_sop[k] = 0; end
    run_scan(2);
    m_own[2] = 0;
    run_scan(1);

    // directed lap fallback (R8)
    lookahead_en = 1; poll_interval = 3;
    for (int k = 0; k < 6; k++) begin m_own[k] = 0; m_sop[k] = 0; end
    m_own[3] = 1;
    pulse_done(1);
    wait_reads(2, 4, "R8");
    begin
      int bad = -1;
      for (int k = 0; k < 6; k++) if (k != 2 && reads[k] != 1) bad = k;
      chk(bad < 0, "R8", "no walk beyond one lap", bad, -1);
    end
    chk(m_own[3] == 0, "R3", "reclaimed during lap", m_own[3], 0);
    m_sop[2] = 1; m_own[2] = 1;
    wait_ready("R8");
    @(negedge clk);
    chk(next_idx == 2, "R8", "fallback result index", next_idx, 2);

    // constrained random scans
    for (int n = 0; n < 40; n++) begin
      int len;
      len = 2 + ($urandom % 23);
      ring_len = LEN_W'(len);
      ring_base = $urandom & 32'h0fff_fff0;
      poll_interval = POLL_W'($urandom % 5);
      lookahead_en = ($urandom % 4) != 0;
      fill_random(len);
      run_scan($urandom % len);
    end

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule